// File: doc/BRIEF.md
# External Bus Request/Grant Arbiter

This block lets an outside master take over a processor's external memory bus. The request pin is asynchronous. It passes through a synchronizer and then feeds a small grant state machine. The state machine hands the bus over only at an external-access boundary. The core reports that boundary as a cycle in which `ext_busy` is low. Because of this, a grant can fall between two accesses that belong to a single instruction.

While the bus is granted away, the block turns off the drivers for address, data and memory strobes. It also stops the core. In the run-while-granted mode, the core keeps executing internal work and is stopped only once it needs the external bus. A hung flag reports that the core is stopped because it is waiting for the bus.

When the request is withdrawn, the block releases the grant, turns the drivers back on and lets the core continue. The core then carries out its pending access. Requests are served even while the block's reset is asserted.

Top module: `bus_grant_arbiter`

## Requirements
- R1: With `ext_busy` low, a rise of `bus_req` sets `bus_grant` high on the third rising clock edge after the change, and not earlier.
- R2: `bus_grant` never rises on an edge where `ext_busy` was high in the cycle before it. A request made during an access is granted on the edge that ends the first cycle with `ext_busy` low, even when a further access of the same instruction follows.
- R3: `drv_en` is low in exactly the cycles where `bus_grant` is high, so the drivers are off in the same cycle the grant appears.
- R4: With `go_mode` low, `core_halt` is high in every cycle where `bus_grant` is high.
- R5: With `go_mode` high and the bus granted, `core_halt` follows `ext_need`: the core runs while it needs no external access and stops when it does.
- R6: `grant_hung` is high exactly when `bus_grant` is high and `ext_need` is high.
- R7: After `bus_req` falls, `bus_grant` drops on the third rising edge. In that same cycle `drv_en` returns high and `core_halt` and `grant_hung` clear.
- R8: While `rst_n` is low, a held `bus_req` is still granted with the R1 latency. A reset with `bus_req` low leaves `bus_grant` low and `drv_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; grant follows the synchronized request during reset |
| bus_req | input | 1 | Asynchronous bus request from the external master |
| ext_busy | input | 1 | Core has an external access on the bus this cycle |
| ext_need | input | 1 | Core needs the external bus (pending memory or DMA access) |
| go_mode | input | 1 | 1: core keeps running while granted until it needs the bus |
| bus_grant | output | 1 | Registered bus grant to the external master |
| grant_hung | output | 1 | Bus granted away while the core waits for it |
| drv_en | output | 1 | Enable for address, data and strobe drivers |
| core_halt | output | 1 | Stall request to the core |

## Verification
The embedded assertions check four rules on every cycle:
- a grant never starts or ends against the synchronized request;
- a grant never starts right after a busy cycle;
- the driver enable is always the complement of the grant;
- the halt and hung outputs match the mode and the need signal.

Some properties can only be shown by the bench scenarios. These are the exact three-edge latency in both directions, a grant that lands in the one idle gap between two accesses, and the grant that works while reset is held.

// File: rtl/bus_grant_arbiter.sv
module bus_grant_arbiter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic ext_busy,
  input  logic ext_need,
  input  logic go_mode,
  output logic bus_grant,
  output logic grant_hung,
  output logic drv_en,
  output logic core_halt
);

  logic [SYNC_STAGES-1:0] req_sync;
  logic req_s;
  logic grant_q;
  logic drv_q;

  always_ff @(posedge clk)
    req_sync <= {req_sync[SYNC_STAGES-2:0], bus_req};

  assign req_s = req_sync[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= req_s;
      drv_q   <= !req_s;
    end else if (!grant_q) begin
      if (req_s && !ext_busy) begin
        grant_q <= 1'b1;
        drv_q   <= 1'b0;
      end
    end else if (!req_s) begin
      grant_q <= 1'b0;
      drv_q   <= 1'b1;
    end
  end

  assign bus_grant  = grant_q;
  assign drv_en     = drv_q;
  assign grant_hung = grant_q & ext_need;
  assign core_halt  = grant_q & (go_mode ? ext_need : 1'b1);

  assert_grant_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_grant) |-> $past(req_s));

  assert_no_grant_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bus_grant) && $past(rst_n)) |-> !$past(ext_busy));

  assert_drivers_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en == !bus_grant);

  assert_halt_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && !go_mode) |-> core_halt);

  assert_go_runs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go_mode && !ext_need) |-> !core_halt);

  assert_hung_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_hung |-> (bus_grant && ext_need));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bus_grant) && $past(rst_n)) |-> !$past(req_s));

endmodule

// File: tb/bus_grant_arbiter_tb.sv
module bus_grant_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n, bus_req, ext_busy, ext_need, go_mode;
  logic bus_grant, grant_hung, drv_en, core_halt;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_grant_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .ext_busy(ext_busy),
    .ext_need(ext_need), .go_mode(go_mode), .bus_grant(bus_grant),
    .grant_hung(grant_hung), .drv_en(drv_en), .core_halt(core_halt)
  );

  // {req, busy, need, go, grant, halt, hung, drv}
  localparam logic [7:0] VEC [8] = '{
    8'b0000_0001, 8'b1000_1100, 8'b1010_1110, 8'b1001_1000,
    8'b1011_1110, 8'b0011_0001, 8'b1100_0001, 8'b0100_0001
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got grant/halt/hung/drv=%b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {bus_grant, core_halt, grant_hung, drv_en};
  endfunction

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; ext_busy = 1'b0; ext_need = 1'b0; go_mode = 1'b0;
    tick(4);
    check("R8 reset idle", outs(), 4'b0001);
    rst_n = 1'b1;
    tick(1);

    // table walk: settled outputs for held inputs (R4 R5 R6 R3 R2)
    foreach (VEC[i]) begin
      {bus_req, ext_busy, ext_need, go_mode} = VEC[i][7:4];
      tick(4);
      check($sformatf("R4/R5/R6 vector %0d", i), outs(), VEC[i][3:0]);
    end

    // R1 latency
    {bus_req, ext_busy, ext_need, go_mode} = 4'b0000;
    tick(4);
    bus_req = 1'b1;
    tick(2);
    check("R1 not before third edge", outs(), 4'b0001);
    tick(1);
    check("R1 grant on third edge", outs(), 4'b1100);

    // R7 release
    ext_need = 1'b1;
    tick(1);
    check("R6 hung while needing", outs(), 4'b1110);
    bus_req = 1'b0;
    tick(2);
    check("R7 still granted", outs(), 4'b1110);
    tick(1);
    check("R7 released", outs(), 4'b0001);
    ext_need = 1'b0;

    // R2 grant in gap between two accesses
    ext_busy = 1'b1; bus_req = 1'b1;
    tick(5);
    check("R2 held off during access", outs(), 4'b0001);
    ext_busy = 1'b0;
    tick(1);
    ext_busy = 1'b1;
    check("R2 granted in gap", outs(), 4'b1100);
    ext_busy = 1'b0;
    bus_req = 1'b0;
    tick(4);
    check("R7 back to idle", outs(), 4'b0001);

    // R8 request honoured during reset
    rst_n = 1'b0;
    tick(1);
    bus_req = 1'b1;
    tick(2);
    check("R8 reset latency early", outs(), 4'b0001);
    tick(1);
    check("R8 granted in reset", outs(), 4'b1100);
    bus_req = 1'b0;
    tick(3);
    check("R8 release in reset", outs(), 4'b0001);
    rst_n = 1'b1;
    tick(1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule